// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter. It advances on the instruction-cycle enable after a selectable prescaler divides that enable. On every prescaled tick the counter is compared with a programmable period value. When the two are equal, the counter returns to zero instead of incrementing, and a one-clock match pulse is raised. The match pulse is also brought out so that a synchronous serial port can use it as a bit clock, or a PWM generator can use it as a time base.

A postscaler counts match events. After a programmable number of matches it sets a sticky interrupt flag. Software clears the flag explicitly. Loading the counter, or switching the timer off, discards any partial progress in both the prescaler and the postscaler. The only count source is the instruction-cycle enable.

Top module: `pm_timer`

## Requirements
- R1: After reset, `count` is 0, `match_pulse` is 0, `irq_flag` is 0 and the period value is 8'hFF.
- R2: `count` advances by one only on a prescaled tick, which requires `run` and `cyc_en` both high. `pre_sel` 2'b00 gives a tick on every enabled cycle, 2'b01 on every 4th and 2'b10 or 2'b11 on every 16th. Without a tick, `count` holds.
- R3: On a tick where `count` equals the period value, `count` becomes 0 and `match_pulse` is high for exactly the following clock. On every other clock `match_pulse` is low.
- R4: A period value of 0 yields a match on every tick, with `count` staying at 0.
- R5: `irq_flag` is set on the same clock as the match pulse of the (`post_sel`+1)-th match since the postscaler was last cleared, so `post_sel` 4'd0 gives 1:1 and 4'd15 gives 1:16.
- R6: `irq_flag` stays set until `flag_clr` is high. When a postscaler terminal match coincides with `flag_clr`, the flag is set.
- R7: `cnt_wr` loads `cnt_wdata` into `count` on the next clock, clears the prescaler and postscaler progress, and overrides any tick in that cycle, so no match occurs.
- R8: While `run` is low, `count` holds, `match_pulse` stays low and the prescaler and postscaler progress is cleared.
- R9: `per_wr` loads `per_wdata` as the period value, and it is used from the following tick onward. A count above the period value keeps counting up, wraps from 255 to 0 without a match, and then matches on equality.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Instruction-cycle enable, the count source |
| run | input | 1 | Timer on when high |
| pre_sel | input | 2 | Prescaler select: 0 is /1, 1 is /4, 2 or 3 is /16 |
| post_sel | input | 4 | Postscaler ratio minus one |
| per_wr | input | 1 | Period value write strobe |
| per_wdata | input | 8 | Period value to load |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter value to load |
| flag_clr | input | 1 | Clears the interrupt flag |
| count | output | 8 | Current counter value |
| match_pulse | output | 1 | One-clock pulse after each period match |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The counter is run with a continuous enable at /1 and with a gapped, random enable at /4 and /16. These runs separate prescaler spacing errors from errors in gating on the enable. Small, zero and 255 period values distinguish the wrap-on-equality behaviour from plain 8-bit overflow, and a counter loaded above the period checks that only equality matches. A final random phase mixes counter writes, period writes, run toggles and flag clears, some of which coincide with terminal matches, and compares every clock against a behavioural model. That phase exposes errors in priority order and in clearing the prescaler and postscaler.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

  typedef enum logic [1:0] {
    PRE_DIV1  = 2'd0,
    PRE_DIV4  = 2'd1,
    PRE_DIV16 = 2'd2,
    PRE_DIV16B = 2'd3
  } pre_sel_e;

  localparam int unsigned PRE_CNT_W = 4;

  // terminal value of the prescaler counter for a given selection
  function automatic logic [PRE_CNT_W-1:0] pre_last(input logic [1:0] sel);
    case (sel)
      PRE_DIV1: pre_last = PRE_CNT_W'(0);
      PRE_DIV4: pre_last = PRE_CNT_W'(3);
      default:  pre_last = PRE_CNT_W'(15);
    endcase
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import pmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       cyc_en,
  input  logic       clr,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PRE_CNT_W-1:0] pre_q;
  logic [PRE_CNT_W-1:0] last;

  assign last = pre_last(sel);
  // >= keeps the divider safe when sel shrinks mid-count
  assign tick = run & cyc_en & ~clr & (pre_q >= last);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) begin
      pre_q <= '0;
    end else if (cyc_en) begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             match_ev,
  output logic             match_q
);
  logic [CNT_W-1:0] per_q;

  assign match_ev = tick & (cnt_q == per_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= '1;
    end else if (per_wr) begin
      per_q <= per_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= match_ev & ~ld;
      if (ld) begin
        cnt_q <= ld_val;
      end else if (tick) begin
        cnt_q <= match_ev ? '0 : cnt_q + 1'b1;
      end
    end
  end

  AST_MATCH_ZERO: assert property (@(posedge clk) disable iff (rst)
    match_q |-> (cnt_q == '0)); // R3

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld) |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/tmr_postscaler.sv
module tmr_postscaler #(
  parameter int unsigned POST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              match_ev,
  input  logic [POST_W-1:0] ratio_sel,
  input  logic              flag_clr,
  output logic              flag
);
  logic [POST_W-1:0] post_q;
  logic              term;

  assign term = match_ev & (post_q >= ratio_sel);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      post_q <= '0;
    end else if (match_ev) begin
      post_q <= term ? '0 : post_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (term) begin
      flag <= 1'b1;
    end else if (flag_clr) begin
      flag <= 1'b0;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag); // R6

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !match_ev) |=> !flag); // R6

endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned POST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_en,
  input  logic              run,
  input  logic [1:0]        pre_sel,
  input  logic [POST_W-1:0] post_sel,
  input  logic              per_wr,
  input  logic [CNT_W-1:0]  per_wdata,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              flag_clr,
  output logic [CNT_W-1:0]  count,
  output logic              match_pulse,
  output logic              irq_flag
);
  logic tick;
  logic match_ev;
  logic scal_clr;

  assign scal_clr = cnt_wr | ~run;

  tmr_prescaler u_pre (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .cyc_en (cyc_en),
    .clr    (cnt_wr),
    .sel    (pre_sel),
    .tick   (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .ld       (cnt_wr),
    .ld_val   (cnt_wdata),
    .per_wr   (per_wr),
    .per_val  (per_wdata),
    .cnt_q    (count),
    .match_ev (match_ev),
    .match_q  (match_pulse)
  );

  tmr_postscaler #(.POST_W(POST_W)) u_post (
    .clk       (clk),
    .rst       (rst),
    .clr       (scal_clr),
    .match_ev  (match_ev),
    .ratio_sel (post_sel),
    .flag_clr  (flag_clr),
    .flag      (irq_flag)
  );

  AST_IDLE_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
    !run |=> !match_pulse); // R8

  AST_FLAG_FROM_MATCH: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> match_pulse); // R5

endmodule

// File: tb/pm_timer_tb.sv
module pm_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_en = 1'b0, run = 1'b0;
  logic [1:0] pre_sel = 2'd0;
  logic [3:0] post_sel = 4'd0;
  logic       per_wr = 1'b0, cnt_wr = 1'b0, flag_clr = 1'b0;
  logic [7:0] per_wdata = 8'd0, cnt_wdata = 8'd0;
  logic [7:0] count;
  logic       match_pulse, irq_flag;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_pre, m_cnt, m_per, m_post;
  bit m_match, m_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_timer u_dut (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .run(run), .pre_sel(pre_sel),
    .post_sel(post_sel), .per_wr(per_wr), .per_wdata(per_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .flag_clr(flag_clr),
    .count(count), .match_pulse(match_pulse), .irq_flag(irq_flag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    int div;
    bit tk, mt, term;
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      finish_run();
    end
    if (rst) begin
      m_pre = 0; m_cnt = 0; m_per = 255; m_post = 0; m_match = 0; m_flag = 0;
    end else begin
      div  = (pre_sel == 2'd0) ? 1 : (pre_sel == 2'd1) ? 4 : 16;
      mt   = 0; term = 0;
      if (cnt_wr) begin
        m_cnt = cnt_wdata; m_pre = 0; m_post = 0;
      end else if (!run) begin
        m_pre = 0; m_post = 0;
      end else if (cyc_en) begin
        tk = (m_pre >= div - 1);
        m_pre = tk ? 0 : m_pre + 1;
        if (tk) begin
          if (m_cnt == m_per) begin
            mt = 1; m_cnt = 0;
            if (m_post >= post_sel) begin term = 1; m_post = 0; end
            else m_post++;
          end else m_cnt = (m_cnt + 1) % 256;
        end
      end
      m_match = mt;
      if (term) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (per_wr) m_per = per_wdata;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(count == 8'(m_cnt), "R2/R7/R9 count", count, m_cnt);
      check(match_pulse == m_match, "R3/R4 match_pulse", match_pulse, m_match);
      check(irq_flag == m_flag, "R5/R6 irq_flag", irq_flag, m_flag);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_period(input int v);
    per_wr = 1'b1; per_wdata = 8'(v); step(1); per_wr = 1'b0;
  endtask

  task automatic load_count(input int v);
    cnt_wr = 1'b1; cnt_wdata = 8'(v); step(1); cnt_wr = 1'b0;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    check(count == 8'd0, "R1 count", count, 0);
    check(match_pulse == 1'b0, "R1 match", match_pulse, 0);
    check(irq_flag == 1'b0, "R1 flag", irq_flag, 0);
    // R1 period is 255: count climbs to 255 before the first match
    run = 1'b1; cyc_en = 1'b1;
    step(255);
    check(count == 8'd255, "R1 period 255", count, 255);
    step(1);
    check(match_pulse == 1'b1, "R1 R3 match at 255", match_pulse, 1);

    // R3 period 5, /1, 1:1
    set_period(5); load_count(0);
    step(6);
    check(match_pulse == 1'b1 && count == 8'd0, "R3 wrap at 5", count, 0);
    step(1);
    check(match_pulse == 1'b0, "R3 single pulse", match_pulse, 0);
    check(irq_flag == 1'b1, "R5 1:1 flag", irq_flag, 1);

    // R6 clear without coincidence
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    check(irq_flag == 1'b0, "R6 clear", irq_flag, 0);

    // R4 period 0 matches every tick; clear coinciding with terminal loses
    set_period(0); load_count(0);
    step(3);
    check(match_pulse == 1'b1 && count == 8'd0, "R4 every tick", match_pulse, 1);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    check(irq_flag == 1'b1, "R6 set wins over clear", irq_flag, 1);

    // R8 run low: count holds, no match
    set_period(200); load_count(17);
    run = 1'b0; step(10);
    check(count == 8'd17, "R8 hold", count, 17);
    check(match_pulse == 1'b0, "R8 no match", match_pulse, 0);
    run = 1'b1;

    // R9 count above period wraps through 255 without match
    set_period(10); load_count(250);
    step(6);
    check(count == 8'd0 && match_pulse == 1'b0, "R9 overflow wrap", count, 0);

    // R7 load overrides a matching tick
    set_period(3); load_count(2); step(1);
    cnt_wr = 1'b1; cnt_wdata = 8'd100; step(1); cnt_wr = 1'b0;
    check(count == 8'd100 && match_pulse == 1'b0, "R7 load wins", count, 100);

    // R2 /4 and /16 with gapped enable, R5 ratios
    set_period(3); post_sel = 4'd3; pre_sel = 2'd1; load_count(0);
    for (int i = 0; i < 600; i++) begin
      cyc_en = ($urandom_range(0, 2) != 0); step(1);
    end
    set_period(10); post_sel = 4'd15; pre_sel = 2'd2;
    for (int i = 0; i < 2500; i++) begin
      cyc_en = ($urandom_range(0, 3) != 0); step(1);
    end

    // mixed random phase
    for (int i = 0; i < 4000; i++) begin
      cyc_en    = ($urandom_range(0, 3) != 0);
      run       = ($urandom_range(0, 40) != 0);
      pre_sel   = 2'($urandom_range(0, 3));
      post_sel  = 4'($urandom_range(0, 3));
      per_wr    = ($urandom_range(0, 60) == 0);
      per_wdata = 8'($urandom_range(0, 6));
      cnt_wr    = ($urandom_range(0, 80) == 0);
      cnt_wdata = 8'($urandom_range(0, 8));
      flag_clr  = ($urandom_range(0, 5) == 0);
      step(1);
    end
    per_wr = 1'b0; cnt_wr = 1'b0; flag_clr = 1'b0;
    step(2);
    done = 1'b1;
    finish_run();
  end

endmodule